// File: doc/BRIEF.md
# I2C Master Transfer Engine

This block is a single-master I2C bus engine. A host hands it one command at a time (start, write a byte, read a byte, stop). It turns each command into the matching bus activity on two open-drain lines: start and stop conditions, eight data bits with one clock pulse each, and the ninth acknowledge pulse. It reports one response per command: the byte it sampled from the bus and the level of SDA on the acknowledge pulse.

The engine never drives a line high. It pulls SCL or SDA low by raising an output enable, and it lets the line float high by dropping that enable. Both lines are read back through a small synchroniser. The length of each SCL phase comes from a divider value on a plain input. The high-phase count only begins once SCL actually reads high, so a slave that holds SCL low stretches the clock and the master simply waits.

Commands and responses are valid/ready streams. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until that command's response has been taken. A response stays on `rsp_valid`/`rsp_data`/`rsp_nack`, unchanged, until `rsp_ready` is high at a clock edge. Holding `rsp_ready` low therefore stalls the acceptance of the next command.

Top module: `i2c_xfer_engine`

## Requirements
- R1: After reset both output enables are low (lines released), `cmd_ready` is high, and `rsp_valid` and `busy` are low.
- R2: Command code 0 (start) makes SDA fall while SCL is high, then pulls SCL low, leaving the bus held with both lines low. A start on a held bus first releases SDA while SCL is low, which gives a repeated start. Its response is data 0, nack 0.
- R3: Command code 3 (stop) on a held bus makes SDA rise while SCL is high and leaves both lines released. Its response is data 0, nack 0.
- R4: Command code 1 (write) produces exactly nine SCL pulses. The eight data bits of `cmd_data` go out most significant bit first. SDA changes only while SCL is low, except for the edges of start and stop conditions. `rsp_data` returns the eight SDA levels sampled on those pulses.
- R5: On the ninth pulse of a write the engine releases SDA, and `rsp_nack` reports the sampled SDA level (0 = acknowledged, 1 = not acknowledged).
- R6: Command code 2 (read) releases SDA for eight pulses and returns the sampled bits, most significant bit first, in `rsp_data`.
- R7: On the ninth pulse of a read, the engine pulls SDA low when `cmd_nack` is 0 and leaves it released when `cmd_nack` is 1. `rsp_nack` reports that level.
- R8: Each SCL high time on a data pulse lasts at least `clk_div`+1 and at most `clk_div`+SYNC_STAGES+2 clock cycles. This holds even when a slave holds SCL low first. While SCL reads low, the engine keeps SCL released and waits.
- R9: A write, read or stop issued while the bus is not held makes no bus activity and responds with data 0, nack 1.
- R10: `cmd_ready` is low from the acceptance of a command until its response is taken. A response held under a low `rsp_ready` keeps its data and nack values.
- R11: `busy` is high while an accepted command is being carried out on the bus and low once its response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clk_div | input | DIV_W | Cycles per SCL phase, minus one |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_data | input | DATA_W | Byte to write |
| cmd_nack | input | 1 | Read: 1 leaves the ninth bit high (nack) |
| rsp_valid | output | 1 | Response presented |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DATA_W | Bits sampled on the data pulses |
| rsp_nack | output | 1 | SDA level on the ninth pulse |
| busy | output | 1 | Command in progress on the bus |
| scl_in | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench builds the engine with its defaults, DIV_W = 8, DATA_W = 8 and SYNC_STAGES = 2. It drives `clk_div` at 3 and later at 6. The small divider keeps each byte within a few dozen cycles, so starts, repeated starts, ack and nack in both directions, refused commands and a 60-cycle clock stretch all fit into one short run. The change to 6 shows that the measured SCL high window follows the divider input rather than a fixed value.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } xfer_op_e;

  typedef enum logic [1:0] {
    BK_START = 2'd0,
    BK_STOP  = 2'd1,
    BK_DATA  = 2'd2
  } bit_kind_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];

endmodule

// File: rtl/i2c_bit_ctrl.sv
module i2c_bit_ctrl
  import i2c_xfer_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             go,
  input  bit_kind_e        kind,
  input  logic             tx,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             done,
  output logic             rx,
  output logic             scl_oe,
  output logic             sda_oe
);

  typedef enum logic [3:0] {
    B_IDLE, B_ST_A, B_ST_B, B_ST_C,
    B_D_LOW, B_D_HIGH,
    B_SP_A, B_SP_B, B_SP_C
  } bstate_e;

  bstate_e          state;
  logic [DIV_W-1:0] cnt;
  logic             cnt_zero;
  logic             hi_wait;

  assign cnt_zero = (cnt == '0);
  assign hi_wait  = (state == B_ST_B) || (state == B_D_HIGH) || (state == B_SP_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= B_IDLE;
      cnt    <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      rx     <= 1'b1;
    end else begin
      done <= 1'b0;
      case (state)
        B_IDLE: begin
          if (go) begin
            cnt <= clk_div;
            case (kind)
              BK_START: begin
                sda_oe <= 1'b0;
                state  <= B_ST_A;
              end
              BK_STOP: begin
                sda_oe <= 1'b1;
                scl_oe <= 1'b1;
                state  <= B_SP_A;
              end
              default: begin
                scl_oe <= 1'b1;
                sda_oe <= !tx;
                state  <= B_D_LOW;
              end
            endcase
          end
        end
        // start: SDA released, then SCL released, then SDA pulled low
        B_ST_A: begin
          if (cnt_zero) begin
            scl_oe <= 1'b0;
            cnt    <= clk_div;
            state  <= B_ST_B;
          end else cnt <= cnt - 1'b1;
        end
        B_ST_B: begin
          if (!scl_s) cnt <= clk_div;
          else if (cnt_zero) begin
            sda_oe <= 1'b1;
            cnt    <= clk_div;
            state  <= B_ST_C;
          end else cnt <= cnt - 1'b1;
        end
        B_ST_C: begin
          if (cnt_zero) begin
            scl_oe <= 1'b1;
            done   <= 1'b1;
            state  <= B_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        // data bit: low phase with SDA set, high phase counted after SCL seen high
        B_D_LOW: begin
          if (cnt_zero) begin
            scl_oe <= 1'b0;
            cnt    <= clk_div;
            state  <= B_D_HIGH;
          end else cnt <= cnt - 1'b1;
        end
        B_D_HIGH: begin
          if (!scl_s) cnt <= clk_div;
          else if (cnt_zero) begin
            rx     <= sda_s;
            scl_oe <= 1'b1;
            done   <= 1'b1;
            state  <= B_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        // stop: SDA low under low SCL, SCL released, then SDA released
        B_SP_A: begin
          if (cnt_zero) begin
            scl_oe <= 1'b0;
            cnt    <= clk_div;
            state  <= B_SP_B;
          end else cnt <= cnt - 1'b1;
        end
        B_SP_B: begin
          if (!scl_s) cnt <= clk_div;
          else if (cnt_zero) begin
            sda_oe <= 1'b0;
            cnt    <= clk_div;
            state  <= B_SP_C;
          end else cnt <= cnt - 1'b1;
        end
        B_SP_C: begin
          if (cnt_zero) begin
            done  <= 1'b1;
            state <= B_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= B_IDLE;
      endcase
    end
  end

  // R4: SDA moves under a released SCL only as the edge of a start or stop
  p_sda_quiet_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(scl_oe)) |->
      ($past(state) == B_ST_B || $past(state) == B_SP_B));

  // R8: while SCL reads low during a high phase, SCL stays released
  p_wait_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wait && !scl_s) |=> !scl_oe);

  // R8: a new bit only starts from the idle state
  p_go_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state == B_IDLE));

endmodule

// File: rtl/i2c_byte_ctrl.sv
module i2c_byte_ctrl
  import i2c_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_nack,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_nack,
  output logic              busy,
  output logic              bit_go,
  output bit_kind_e         bit_kind,
  output logic              bit_tx,
  input  logic              bit_done,
  input  logic              bit_rx
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT, C_RESP} cstate_e;

  cstate_e           state;
  xfer_op_e          op_q;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [CNT_W-1:0]  bidx;
  logic              nack_sel;
  logic              nack_q;
  logic              held;
  logic              accept;

  assign accept    = cmd_valid && cmd_ready;
  assign cmd_ready = (state == C_IDLE);
  assign rsp_valid = (state == C_RESP);
  assign busy      = (state == C_ISSUE) || (state == C_WAIT);
  assign bit_go    = (state == C_ISSUE);
  assign rsp_data  = rx_sh;
  assign rsp_nack  = nack_q;

  always_comb begin
    case (op_q)
      OP_START: bit_kind = BK_START;
      OP_STOP:  bit_kind = BK_STOP;
      default:  bit_kind = BK_DATA;
    endcase
    bit_tx = 1'b1;
    if (op_q == OP_WRITE && bidx != LAST)     bit_tx = tx_sh[DATA_W-1];
    else if (op_q == OP_READ && bidx == LAST) bit_tx = nack_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= C_IDLE;
      op_q     <= OP_START;
      tx_sh    <= '0;
      rx_sh    <= '0;
      bidx     <= '0;
      nack_sel <= 1'b0;
      nack_q   <= 1'b0;
      held     <= 1'b0;
    end else begin
      case (state)
        C_IDLE: begin
          if (accept) begin
            op_q     <= xfer_op_e'(cmd_op);
            tx_sh    <= cmd_data;
            rx_sh    <= '0;
            bidx     <= '0;
            nack_sel <= cmd_nack;
            nack_q   <= 1'b0;
            if (xfer_op_e'(cmd_op) != OP_START && !held) begin
              nack_q <= 1'b1;
              state  <= C_RESP;
            end else begin
              state <= C_ISSUE;
            end
          end
        end
        C_ISSUE: state <= C_WAIT;
        C_WAIT: begin
          if (bit_done) begin
            case (op_q)
              OP_START: begin
                held  <= 1'b1;
                state <= C_RESP;
              end
              OP_STOP: begin
                held  <= 1'b0;
                state <= C_RESP;
              end
              default: begin
                if (bidx != LAST) begin
                  rx_sh <= {rx_sh[DATA_W-2:0], bit_rx};
                  tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                  bidx  <= bidx + 1'b1;
                  state <= C_ISSUE;
                end else begin
                  nack_q <= bit_rx;
                  state  <= C_RESP;
                end
              end
            endcase
          end
        end
        C_RESP: if (rsp_ready) state <= C_IDLE;
        default: state <= C_IDLE;
      endcase
    end
  end

  // R10: a held response keeps its content
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_nack)));

  // R10: taking a command closes the command side
  p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);

  // R9: a bus command on a free bus is refused at once with nack
  p_refuse_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op != 2'd0 && !held) |=> (rsp_valid && rsp_nack && !busy));

  // R4: never more than nine pulses per byte command
  p_bit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bidx <= LAST);

endmodule

// File: rtl/i2c_xfer_engine.sv
module i2c_xfer_engine
  import i2c_xfer_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_nack,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_nack,
  output logic              busy,
  input  logic              scl_in,
  output logic              scl_oe,
  input  logic              sda_in,
  output logic              sda_oe
);

  logic      scl_s, sda_s;
  logic      bit_go, bit_tx, bit_done, bit_rx;
  bit_kind_e bit_kind;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  i2c_byte_ctrl #(.DATA_W(DATA_W)) u_byte (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_nack(rsp_nack), .busy(busy),
    .bit_go(bit_go), .bit_kind(bit_kind), .bit_tx(bit_tx),
    .bit_done(bit_done), .bit_rx(bit_rx));

  i2c_bit_ctrl #(.DIV_W(DIV_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .go(bit_go), .kind(bit_kind), .tx(bit_tx),
    .scl_s(scl_s), .sda_s(sda_s),
    .done(bit_done), .rx(bit_rx), .scl_oe(scl_oe), .sda_oe(sda_oe));

  // R11: busy and a presented response never overlap
  p_busy_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rsp_valid));

endmodule

// File: tb/i2c_xfer_engine_test.sv
module i2c_xfer_engine_test;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [7:0] clk_div;
  logic       cmd_valid, cmd_ready, cmd_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic       rsp_valid, rsp_ready, rsp_nack, busy;
  logic [7:0] rsp_data;
  logic       scl_oe, sda_oe, scl_line, sda_line;
  logic       slv_scl_hold, slv_sda_low;

  assign scl_line = !scl_oe && !slv_scl_hold;
  assign sda_line = !sda_oe && !slv_sda_low;

  i2c_xfer_engine #(.DIV_W(8), .DATA_W(8), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_nack(rsp_nack), .busy(busy),
    .scl_in(scl_line), .scl_oe(scl_oe), .sda_in(sda_line), .sda_oe(sda_oe));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // slave model: 0 idle, 1 receive (write), 2 transmit (read)
  int         slv_mode = 0;
  int         slv_idx = 0;
  logic [7:0] slv_byte = 8'h00;
  logic       slv_ack = 1'b0;

  task automatic slv_update();
    if (slv_mode == 2 && slv_idx < 8)       slv_sda_low = !slv_byte[7 - slv_idx];
    else if (slv_mode == 1 && slv_idx == 8) slv_sda_low = slv_ack;
    else                                    slv_sda_low = 1'b0;
  endtask

  always @(negedge scl_line) begin
    slv_idx++;
    slv_update();
  end

  // line monitor
  int         pulse_cnt = 0;
  logic [8:0] line_bits = '0;
  int         start_cnt = 0, stop_cnt = 0;
  bit         meas = 0;
  int         hi_run = 0, hi_min = 1000, hi_max = 0;

  always @(posedge scl_line) begin
    line_bits = {line_bits[7:0], sda_line};
    pulse_cnt++;
  end
  always @(negedge sda_line) if (scl_line) start_cnt++;
  always @(posedge sda_line) if (scl_line) stop_cnt++;

  always @(negedge clk) begin
    if (meas) begin
      if (scl_line) hi_run++;
      else if (hi_run > 0) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
    end
  end

  // scoreboard
  typedef struct {
    logic [7:0] data;
    logic       nack;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  int   t_issue = 0, t_done = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_data == e.data, {e.tag, " data"}, int'(rsp_data), int'(e.data));
        check(rsp_nack == e.nack, {e.tag, " nack"}, int'(rsp_nack), int'(e.nack));
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic nk,
                       input logic [7:0] ed, input logic en, input string tag);
    exp_q.push_back('{ed, en, tag});
    pulse_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_nack = nk;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    t_issue = cyc;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    t_done = cyc;
    @(negedge clk);
  endtask

  task automatic data_cmd(input logic [1:0] op, input logic [7:0] d, input logic nk,
                          input logic [7:0] ed, input logic en, input string tag);
    hi_run = 0; hi_min = 1000; hi_max = 0; meas = 1;
    issue(op, d, nk, ed, en, tag);
    wait_done();
    meas = 0;
    check(pulse_cnt == 9, "R4 nine pulses", pulse_cnt, 9);
    check(hi_min >= int'(clk_div) + 1, "R8 high time min", hi_min, int'(clk_div) + 1);
    check(hi_max <= int'(clk_div) + SYNC + 2, "R8 high time max", hi_max, int'(clk_div) + SYNC + 2);
  endtask

  task automatic slv_set(input int mode, input logic [7:0] b, input logic ack);
    slv_mode = mode; slv_byte = b; slv_ack = ack; slv_idx = 0;
    slv_update();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_div = 8'd3;
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_data = 8'h00; cmd_nack = 1'b0;
    rsp_ready = 1'b1; slv_scl_hold = 1'b0; slv_sda_low = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    start_cnt = 0; stop_cnt = 0;

    // R1 reset state
    check(scl_oe == 0, "R1 scl_oe", scl_oe, 0);
    check(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
    check(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
    check(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    check(busy == 0, "R1 busy", busy, 0);

    // R9 refused commands on a free bus
    issue(2'd1, 8'hFF, 1'b0, 8'h00, 1'b1, "R9 write free");
    check(busy == 0, "R9 busy stays low", busy, 0);
    wait_done();
    issue(2'd2, 8'h00, 1'b0, 8'h00, 1'b1, "R9 read free");
    wait_done();
    issue(2'd3, 8'h00, 1'b0, 8'h00, 1'b1, "R9 stop free");
    wait_done();
    check(pulse_cnt == 0, "R9 no pulses", pulse_cnt, 0);
    check(start_cnt + stop_cnt == 0, "R9 no conditions", start_cnt + stop_cnt, 0);
    check(scl_line && sda_line, "R9 lines high", int'({scl_line, sda_line}), 3);

    // R2 start
    slv_set(0, 8'h00, 1'b0);
    issue(2'd0, 8'h00, 1'b0, 8'h00, 1'b0, "R2 start");
    check(busy == 1, "R11 busy during start", busy, 1);
    wait_done();
    check(busy == 0, "R11 busy after start", busy, 0);
    check(start_cnt == 1, "R2 start condition", start_cnt, 1);
    check(!scl_line && !sda_line, "R2 bus held low", int'({scl_line, sda_line}), 0);

    // R4/R5 write acknowledged
    slv_set(1, 8'h00, 1'b1);
    data_cmd(2'd1, 8'hA5, 1'b0, 8'hA5, 1'b0, "R5 write ack");
    check(line_bits[8:1] == 8'hA5, "R4 bits on line msb first", int'(line_bits[8:1]), 'hA5);
    check(line_bits[0] == 1'b0, "R5 ninth bit low", line_bits[0], 0);

    // R5 write not acknowledged
    slv_set(1, 8'h00, 1'b0);
    data_cmd(2'd1, 8'h3C, 1'b0, 8'h3C, 1'b1, "R5 write nack");
    check(line_bits[8:1] == 8'h3C, "R4 bits on line 3C", int'(line_bits[8:1]), 'h3C);

    // R2 repeated start
    slv_set(0, 8'h00, 1'b0);
    issue(2'd0, 8'h00, 1'b0, 8'h00, 1'b0, "R2 repeated start");
    wait_done();
    check(start_cnt == 2, "R2 repeated start condition", start_cnt, 2);
    check(stop_cnt == 0, "R2 no stop in repeated start", stop_cnt, 0);

    // R6/R7 read with ack, then with nack
    slv_set(2, 8'h96, 1'b0);
    data_cmd(2'd2, 8'h00, 1'b0, 8'h96, 1'b0, "R6 read ack");
    check(line_bits[0] == 1'b0, "R7 master ack low", line_bits[0], 0);
    slv_set(2, 8'h5A, 1'b0);
    data_cmd(2'd2, 8'h00, 1'b1, 8'h5A, 1'b1, "R6 read nack");
    check(line_bits[0] == 1'b1, "R7 master nack high", line_bits[0], 1);

    // R3 stop
    slv_set(0, 8'h00, 1'b0);
    issue(2'd3, 8'h00, 1'b0, 8'h00, 1'b0, "R3 stop");
    wait_done();
    check(stop_cnt == 1, "R3 stop condition", stop_cnt, 1);
    check(scl_line && sda_line, "R3 lines released", int'({scl_line, sda_line}), 3);
    check(!scl_oe && !sda_oe, "R3 enables low", int'({scl_oe, sda_oe}), 0);

    // R8 clock stretching by the slave
    issue(2'd0, 8'h00, 1'b0, 8'h00, 1'b0, "R2 start again");
    wait_done();
    slv_set(1, 8'h00, 1'b1);
    slv_scl_hold = 1'b1;
    hi_run = 0; hi_min = 1000; hi_max = 0; meas = 1;
    issue(2'd1, 8'hC3, 1'b0, 8'hC3, 1'b0, "R8 stretched write");
    repeat (60) @(negedge clk);
    check(scl_oe == 0, "R8 engine releases scl while stretched", scl_oe, 0);
    slv_scl_hold = 1'b0;
    wait_done();
    meas = 0;
    check(t_done - t_issue >= 60, "R8 waited for stretch", t_done - t_issue, 60);
    check(pulse_cnt == 9, "R8 nine pulses stretched", pulse_cnt, 9);
    check(hi_min >= int'(clk_div) + 1, "R8 stretched high min", hi_min, int'(clk_div) + 1);
    check(hi_max <= int'(clk_div) + SYNC + 2, "R8 stretched high max", hi_max, int'(clk_div) + SYNC + 2);

    // R10 back-pressure on the response side
    rsp_ready = 1'b0;
    slv_set(0, 8'h00, 1'b0);
    issue(2'd0, 8'h00, 1'b0, 8'h00, 1'b0, "R10 held response");
    repeat (100) @(negedge clk);
    check(rsp_valid == 1, "R10 response waits", rsp_valid, 1);
    check(cmd_ready == 0, "R10 cmd_ready low while held", cmd_ready, 0);
    check(exp_q.size() == 1, "R10 not consumed", exp_q.size(), 1);
    rsp_ready = 1'b1;
    wait_done();
    check(cmd_ready == 1, "R10 cmd_ready back", cmd_ready, 1);

    // R8 divider value changed
    clk_div = 8'd6;
    slv_set(1, 8'h00, 1'b1);
    data_cmd(2'd1, 8'h81, 1'b0, 8'h81, 1'b0, "R4 write div 6");
    slv_set(0, 8'h00, 1'b0);
    issue(2'd3, 8'h00, 1'b0, 8'h00, 1'b0, "R3 final stop");
    wait_done();
    check(stop_cnt == 2, "R3 final stop count", stop_cnt, 2);
    check(start_cnt == 4, "R2 total starts", start_cnt, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule